// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked system and an external asynchronous static RAM of 2048 words by 8 bits. The system side issues one request at a time: a strobe, a read/write flag, an 11-bit word address and, for a write, 8 bits of data. The controller turns that request into a pin-level memory cycle. It drives active-low chip select, write strobe and output enable, holds the address, and drives the data bus through its own output-enable control. When the cycle is finished, it returns a one-cycle ready pulse, which comes with the captured word if the request was a read.

All memory timing comes from nanosecond limits given as parameters. Each limit is divided by the clock period and rounded up, and every phase lasts at least one clock. A write first holds the address with chip select low and the memory outputs off. Then comes the write-strobe pulse. The pulse ends with the controller still driving data, so setup and hold are measured to the strobe's rising edge. A read keeps chip select and output enable low for the access time and samples the bus on the last edge of that window. The controller enables its data driver only after the memory's outputs have had time to float.

Top module: `asram_port_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the controller sets mem_cs_n, mem_wr_n and mem_rd_n high, mem_dq_oe low and ready_o low.
- R2: A write request drives mem_wr_n low for exactly PULSE_CYC consecutive cycles, where PULSE_CYC is the largest of the rounded-up strobe-width, data-setup and select-to-end limits (3 at the defaults). The word on mem_dq_o is stable while mem_wr_n is low and is the word stored when mem_wr_n rises.
- R3: mem_dq_oe is high from the cycle mem_wr_n falls through the cycle after it rises. It is never high while mem_rd_n is low, and never in the cycle right after mem_rd_n was low.
- R4: mem_rd_n stays high for the whole write cycle. mem_wr_n is low only while mem_cs_n is low.
- R5: A read request holds mem_cs_n and mem_rd_n low with mem_wr_n high for ACC_CYC cycles (4 at the defaults). It captures mem_dq_i on the last edge of that window, and rdata_o shows the captured word in the cycle ready_o is high.
- R6: mem_addr_o holds the accepted address for as long as mem_cs_n is low. mem_wr_n falls only after mem_cs_n has been low for at least one cycle.
- R7: Each accepted request produces exactly one ready_o pulse, one cycle long.
- R8: A request is accepted only in the idle state. A req_i that is high while a cycle is in progress is ignored, and it changes neither the memory nor the address in use.
- R9: After a read, mem_dq_oe rises no sooner than SETUP_CYC cycles after mem_rd_n has returned high (2 at the defaults, from the output-float limit).
- R10: Every timing phase length is its nanosecond limit divided by CLK_PERIOD_NS, rounded up, with a minimum of one cycle. At 4 ns this gives a 12 ns strobe 3 cycles and a 15 ns access 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request strobe, taken only when idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 11 | Word address of the request |
| req_wdata_i | input | 8 | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured read word, valid with ready_o |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_rd_n | output | 1 | Memory output enable, active low |
| mem_addr_o | output | 11 | Memory address |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_i | input | 8 | Data returned from the memory bus |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the memory model returns a valid word on mem_dq_i once chip select and output enable have been low for the access window. They do not assume anything about req_i during a cycle: the pin rules have to hold whatever the system side does. The stimulus raises req_i for a single idle cycle and then waits for ready_o. On purpose, it also holds req_i high with a different address and data during busy cycles, to show that such requests are ignored. The attached memory model drives mem_dq_i only while a read is enabled, and it stores a word at the end of each select-and-strobe overlap.

// File: rtl/asram_pkg.sv
// Shared types and cycle arithmetic for the asynchronous SRAM controller.
// Assumes: all limits are non-negative nanosecond integers.
package asram_pkg;

    // Sequencer states; one write path, one read path, one shared completion state.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_RACC   = 3'd4,
        ST_DONE   = 3'd5
    } seq_state_t;

    // Converts a nanosecond limit to clock cycles, rounding up, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Larger of two cycle counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Phase timer: a loadable down-counter that flags when the current phase
// has reached its final cycle. Assumes load values are phase length minus one.
module asram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R10: a loaded phase lasts at least one cycle; zero only follows a zero load.
    a_r10_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (load_val_i != '0)) |=> !zero_o);

endmodule

// File: rtl/asram_seq.sv
// Cycle sequencer: walks a request through setup, strobe, hold or access
// phases and back to idle. Assumes phase lengths are at least one cycle.
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned PULSE_CYC = 3,
    parameter int unsigned HOLD_CYC  = 1,
    parameter int unsigned ACC_CYC   = 4,
    parameter int unsigned CNT_W     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       req_wr_i,
    output logic       accept_o,
    output logic       capture_o,
    output seq_state_t state_d_o
);

    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_CYC - 1);

    seq_state_t       state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .zero_o    (tmr_zero)
    );

    // Next-state and phase-timer load selection.
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept_o  = 1'b0;
        capture_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    accept_o = 1'b1;
                    tmr_load = 1'b1;
                    if (req_wr_i) begin
                        state_d = ST_WSETUP;
                        tmr_val = SETUP_LD;
                    end else begin
                        state_d = ST_RACC;
                        tmr_val = ACC_LD;
                    end
                end
            end
            ST_WSETUP: begin
                if (tmr_zero) begin
                    state_d  = ST_WPULSE;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LD;
                end
            end
            ST_WPULSE: begin
                if (tmr_zero) begin
                    state_d  = ST_WHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end
            end
            ST_WHOLD: begin
                if (tmr_zero) state_d = ST_DONE;
            end
            ST_RACC: begin
                if (tmr_zero) begin
                    capture_o = 1'b1;
                    state_d   = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_d_o = state_d;

    // R8: a request is only taken from idle.
    a_r8_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (state_q == ST_WSETUP || state_q == ST_RACC));

    // R7: completion always returns to idle on the next cycle.
    a_r7_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/asram_pin_drv.sv
// Pin driver: registers the memory strobes from the next sequencer state,
// holds the address and write word, and captures read data.
// Assumes mem_dq_i is valid once select and output enable have been low
// for the access window.
module asram_pin_drv
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PULSE_CYC = 3,
    parameter int unsigned ACC_CYC   = 4,
    parameter int unsigned CNT_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  seq_state_t        state_d_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_cs_n,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic              ready_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              cs_d, wr_d, rd_d, oe_d;

    // Strobe decode from the state the sequencer is entering.
    always_comb begin
        cs_d = (state_d_i == ST_WSETUP) || (state_d_i == ST_WPULSE) ||
               (state_d_i == ST_WHOLD)  || (state_d_i == ST_RACC);
        wr_d = (state_d_i == ST_WPULSE);
        rd_d = (state_d_i == ST_RACC);
        oe_d = (state_d_i == ST_WPULSE) || (state_d_i == ST_WHOLD);
    end

    // Glitch-free registered strobes and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_wr_n  <= 1'b1;
            mem_rd_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            ready_o   <= 1'b0;
        end else begin
            mem_cs_n  <= !cs_d;
            mem_wr_n  <= !wr_d;
            mem_rd_n  <= !rd_d;
            mem_dq_oe <= oe_d;
            ready_o   <= (state_d_i == ST_DONE);
        end
    end

    // Address and write word held from acceptance to the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept_i) begin
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
        end
    end

    // Read word sampled on the final edge of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (capture_i) rdata_q <= mem_dq_i;
    end

    assign mem_addr_o = addr_q;
    assign mem_dq_o   = wdata_q;
    assign rdata_o    = rdata_q;

    // ---------------- checks ----------------
    localparam logic [CNT_W:0] PULSE_REF = (CNT_W+1)'(PULSE_CYC);
    localparam logic [CNT_W:0] ACC_REF   = (CNT_W+1)'(ACC_CYC - 1);

    logic [CNT_W:0] chk_wr_low;
    logic [CNT_W:0] chk_rd_low;

    // Saturating counts of strobe-low cycles, for width checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_wr_low <= '0;
            chk_rd_low <= '0;
        end else begin
            if (mem_wr_n)               chk_wr_low <= '0;
            else if (chk_wr_low != '1)  chk_wr_low <= chk_wr_low + 1'b1;
            if (mem_rd_n)               chk_rd_low <= '0;
            else if (chk_rd_low != '1)  chk_rd_low <= chk_rd_low + 1'b1;
        end
    end

    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (chk_wr_low >= PULSE_REF));

    a_r2_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n) |-> $stable(mem_dq_o));

    a_r3_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_rd_n && $past(mem_rd_n)));

    a_r3_drive_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> mem_dq_oe);

    a_r3_drive_past_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> mem_dq_oe);

    a_r4_wr_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n) |-> (!mem_cs_n && mem_rd_n));

    a_r5_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n) |-> (mem_wr_n && !mem_cs_n));

    a_r5_access_time: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |-> (!mem_rd_n && chk_rd_low >= ACC_REF));

    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr_o));

    a_r6_wr_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> $past(!mem_cs_n));

    a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

endmodule

// File: rtl/asram_port_ctrl.sv
// Asynchronous SRAM port controller top: derives cycle counts from
// nanosecond limits and joins the sequencer to the pin driver.
// Assumes one outstanding request; requests outside idle are dropped.
module asram_port_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W        = 11,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 4,
    parameter int unsigned T_WR_PULSE_NS = 12,
    parameter int unsigned T_DSETUP_NS   = 10,
    parameter int unsigned T_CS_END_NS   = 12,
    parameter int unsigned T_WR_CYCLE_NS = 15,
    parameter int unsigned T_ACCESS_NS   = 15,
    parameter int unsigned T_RD_CYCLE_NS = 15,
    parameter int unsigned T_FLOAT_NS    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mem_cs_n,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int unsigned SETUP_CYC = ns_to_cyc(T_FLOAT_NS, CLK_PERIOD_NS);
    localparam int unsigned PULSE_CYC = max2(ns_to_cyc(T_WR_PULSE_NS, CLK_PERIOD_NS),
                                        max2(ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_CS_END_NS, CLK_PERIOD_NS)));
    localparam int unsigned WC_CYC    = ns_to_cyc(T_WR_CYCLE_NS, CLK_PERIOD_NS);
    localparam int unsigned HOLD_CYC  = (WC_CYC > SETUP_CYC + PULSE_CYC + 1) ?
                                        (WC_CYC - SETUP_CYC - PULSE_CYC) : 1;
    localparam int unsigned ACC_CYC   = max2(ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_RD_CYCLE_NS, CLK_PERIOD_NS));
    localparam int unsigned MAX_CYC   = max2(max2(SETUP_CYC, PULSE_CYC), max2(HOLD_CYC, ACC_CYC));
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

    logic       accept;
    logic       capture;
    seq_state_t state_d;

    asram_seq #(
        .SETUP_CYC(SETUP_CYC),
        .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC (HOLD_CYC),
        .ACC_CYC  (ACC_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .req_wr_i (req_wr_i),
        .accept_o (accept),
        .capture_o(capture),
        .state_d_o(state_d)
    );

    asram_pin_drv #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PULSE_CYC(PULSE_CYC),
        .ACC_CYC  (ACC_CYC),
        .CNT_W    (CNT_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .capture_i  (capture),
        .state_d_i  (state_d),
        .req_addr_i (req_addr_i),
        .req_wdata_i(req_wdata_i),
        .mem_dq_i   (mem_dq_i),
        .mem_cs_n   (mem_cs_n),
        .mem_wr_n   (mem_wr_n),
        .mem_rd_n   (mem_rd_n),
        .mem_addr_o (mem_addr_o),
        .mem_dq_o   (mem_dq_o),
        .mem_dq_oe  (mem_dq_oe),
        .ready_o    (ready_o),
        .rdata_o    (rdata_o)
    );

endmodule

// File: tb/sim_asram_port_ctrl.sv
// Scoreboard bench with a behavioural asynchronous memory on the pins.
module sim_asram_port_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready;
    logic [7:0]  rdata;
    logic        cs_n, wr_n, rd_n, dq_oe;
    logic [10:0] maddr;
    logic [7:0]  dq_o, dq_i;

    always #2 clk = ~clk;

    asram_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_wr_i(req_wr),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .ready_o(ready), .rdata_o(rdata),
        .mem_cs_n(cs_n), .mem_wr_n(wr_n), .mem_rd_n(rd_n),
        .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe(dq_oe), .mem_dq_i(dq_i)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model and expected contents.
    logic [7:0] model_mem [2048];
    logic [7:0] shadow    [2048];
    logic       wr_act;

    assign dq_i   = (!cs_n && !rd_n && wr_n) ? model_mem[maddr] : 8'hEE;
    assign wr_act = !cs_n && !wr_n;

    // Store at the end of the select-and-strobe overlap.
    always @(negedge wr_act) begin
        if (rst_n) begin
            chk(dq_oe == 1'b1, "R3 driver on at strobe end", int'(dq_oe), 1);
            model_mem[maddr] = dq_o;
        end
    end

    typedef struct { bit is_rd; logic [10:0] a; logic [7:0] d; } item_t;
    item_t       sb_q [$];
    logic [10:0] cur_addr = '0;

    // Monitor: pin timing and scoreboard, sampled on falling edges.
    int  wl = 0, rl = 0, since_rd = 100;
    bit  p_wr_n = 1, p_cs_n = 1, p_oe = 0, p_ready = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (dq_oe) chk(rd_n, "R3 no drive while outputs enabled", int'(rd_n), 1);
            if (!wr_n) begin
                if (p_wr_n) chk(!p_cs_n, "R6 select before strobe", int'(p_cs_n), 0);
                chk(cs_n == 1'b0 && rd_n == 1'b1, "R4 write strobes", int'({cs_n, rd_n}), 1);
                wl++;
            end else if (wl != 0) begin
                chk(wl == 3, "R2 R10 strobe width", wl, 3);
                chk(dq_oe, "R3 drive one cycle past rise", int'(dq_oe), 1);
                wl = 0;
            end
            if (!cs_n) chk(maddr == cur_addr, "R6 address held", int'(maddr), int'(cur_addr));
            if (!rd_n) rl++;
            else if (rl != 0) begin
                chk(rl == 4, "R5 R10 access window", rl, 4);
                rl = 0;
            end
            if (dq_oe && !p_oe) chk(since_rd >= 2, "R9 turnaround", since_rd, 2);
            if (!rd_n) since_rd = 0; else if (since_rd < 100) since_rd++;
            if (ready) begin
                chk(!p_ready, "R7 single cycle ready", int'(p_ready), 0);
                if (sb_q.size() == 0) chk(0, "R7 ready without request", 1, 0);
                else begin
                    item_t it;
                    it = sb_q.pop_front();
                    if (it.is_rd) chk(rdata == it.d, "R5 read data", int'(rdata), int'(it.d));
                    else chk(model_mem[it.a] == it.d, "R2 stored word", int'(model_mem[it.a]), int'(it.d));
                end
            end
            p_wr_n  = wr_n;
            p_cs_n  = cs_n;
            p_oe    = dq_oe;
            p_ready = ready;
        end
    end

    // Driver: one request; optional intruder request held during busy cycles.
    task automatic issue(input bit w, input logic [10:0] a, input logic [7:0] d,
                         input bit intr, input logic [10:0] ia, input logic [7:0] id);
        item_t it;
        @(negedge clk);
        req = 1'b1; req_wr = w; req_addr = a; req_wdata = d; cur_addr = a;
        if (w) shadow[a] = d;
        it.is_rd = !w; it.a = a; it.d = shadow[a];
        sb_q.push_back(it);
        @(negedge clk);
        if (intr) begin
            req_wr = 1'b1; req_addr = ia; req_wdata = id;
            @(negedge clk);
            @(negedge clk);
        end
        req = 1'b0;
        while (!ready) @(negedge clk);
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        issue(1'b1, a, d, 1'b0, '0, '0);
    endtask

    task automatic rd(input logic [10:0] a);
        issue(1'b0, a, '0, 1'b0, '0, '0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin
            model_mem[i] = 8'(i * 7 + 3);
            shadow[i]    = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R1: reset state at the pins
        chk(cs_n && wr_n && rd_n, "R1 strobes high in reset", int'({cs_n, wr_n, rd_n}), 7);
        chk(!dq_oe, "R1 driver off in reset", int'(dq_oe), 0);
        chk(!ready, "R1 ready low in reset", int'(ready), 0);
        rst_n = 1'b1;

        wr(11'd0, 8'hA5);
        wr(11'd2047, 8'h3C);
        rd(11'd0);
        rd(11'd2047);
        rd(11'd100);
        wr(11'd5, 8'h11);
        rd(11'd5);
        wr(11'd6, 8'h66);       // R9: write straight after a read
        rd(11'd6);
        for (int k = 0; k < 20; k++) wr(11'((k * 97) % 2048), 8'(k * 13 + 1));
        for (int k = 0; k < 20; k++) rd(11'((k * 97) % 2048));
        // R8: requests while busy are ignored
        issue(1'b1, 11'd300, 8'h42, 1'b1, 11'd301, 8'hFF);
        rd(11'd301);
        rd(11'd300);
        issue(1'b0, 11'd400, 8'h00, 1'b1, 11'd400, 8'h00);
        rd(11'd400);
        repeat (10) @(negedge clk);
        chk(sb_q.size() == 0, "R7 one ready per request", sb_q.size(), 0);
        finish_run();
    end

endmodule